// File: doc/BRIEF.md
# UART Interrupt Priority Identification Unit

This block collects the interrupt sources of a 16550-style serial port and presents them to software through two registers: an enable register that gates each source and an identification register that names the most urgent pending source with a three-bit code. It also drives one interrupt line toward the system interrupt controller. The serial shifter, the FIFOs, the baud generator and the auto-baud measurement logic sit outside and deliver their conditions as single-bit inputs.

Receive line status, receive data available, character timeout and modem status are level conditions. The unit follows them and does not latch them. A transmit-empty condition is caught on its rising edge and held until software either writes the transmit holding register or reads an identification value that names it. Auto-baud completion and auto-baud timeout arrive as single-cycle pulses. Each is held in a sticky flag that a write-one-to-clear pulse removes. The identification value is held still for the whole of a read strobe, so a source that changes during a read is seen on the following read.

Top module: `uart_irq_id`

## Requirements
- R1: After reset the identification register reads 0x001, the enable register reads 0x000 and irqOut is 0.
- R2: Identification bit 0 is 0 when at least one enabled coded source is pending and 1 otherwise. Bits 3:1 hold the code of the reported source: 3 for line status, 2 for data available, 6 for character timeout, 1 for transmit empty, 0 for modem status. The code is 0 when nothing is pending, and the values 4, 5 and 7 never appear.
- R3: The coded priority, highest first, is line status, then data available, then character timeout, then transmit empty, then modem status.
- R4: While idRdEn is high, idRdData does not change. A source change during the strobe is reported one cycle after the strobe ends.
- R5: Identification bits 7:6 both copy fifoEn, and bits 5:4 read 0.
- R6: ctsChg contributes to the modem status source only if enable bit 3 is set. When autoCts is 1, enable bit 7 must also be set.
- R7: An enable write stores bits 0 to 3 and 7 to 9. Bits 4 to 6 read 0. The new value gates sources from the next cycle on.
- R8: A pulse on abEndIn or abToIn sets a sticky flag. abClr bit 0 clears the end flag and bit 1 clears the timeout flag, and a new pulse in the same cycle wins over the clear. Identification bits 8 and 9 show the end and timeout flags ANDed with enable bits 8 and 9.
- R9: irqOut is a register that holds the OR of all enabled pending sources, including the two auto-baud flags, as they stood one cycle earlier.
- R10: A rising edge on threIn sets the transmit-empty flag. The flag clears on thrWrite, or on the first cycle of a read strobe whose reported value is 0x2 in bits 3:0. A new rising edge in the same cycle wins over the clear.
- R11: Line status, data available, character timeout and modem status follow their inputs with no latching. When the input drops, the source drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ierWrEn | input | 1 | Enable register write strobe |
| ierWrData | input | 10 | Enable register write data |
| ierRdData | output | 10 | Enable register contents |
| idRdEn | input | 1 | Identification read strobe |
| idRdData | output | 10 | Identification register value |
| fifoEn | input | 1 | FIFO-enable control bit |
| autoCts | input | 1 | Automatic CTS flow control mode |
| rlsIn | input | 1 | Receive line status condition |
| rdaIn | input | 1 | Receive data available condition |
| ctiIn | input | 1 | Character timeout condition |
| threIn | input | 1 | Transmit holding register empty |
| thrWrite | input | 1 | Transmit holding register written |
| msIn | input | 1 | Modem status change other than CTS |
| ctsChg | input | 1 | CTS line changed |
| abEndIn | input | 1 | Auto-baud finished pulse |
| abToIn | input | 1 | Auto-baud timed out pulse |
| abClr | input | 2 | Write-one-to-clear for the auto-baud flags |
| irqOut | output | 1 | Interrupt request |

## Verification
A level source or an enable bit that changes before a clock edge reaches idRdData after that edge and reaches irqOut after the same edge. A transmit-empty edge or an auto-baud pulse has to pass through its flag first, so it shows one edge later. The bench drives inputs just after the falling edge. It compares every output shortly afterwards against a cycle model whose registers advance at each rising edge, so each result is checked in exactly the cycle it is due. The directed cases for priority, freezing, CTS gating and transmit-empty clearing step several edges before checking, which lets both one-stage and two-stage paths settle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int IER_W = 10;
  localparam int ID_W = 10;
  localparam int CODE_W = 3;
  localparam logic [IER_W-1:0] IER_MASK = 10'h38F;
  localparam logic [ID_W-1:0] ID_RESET = 10'h001;

  localparam logic [CODE_W-1:0] CODE_RLS = 3'd3;
  localparam logic [CODE_W-1:0] CODE_RDA = 3'd2;
  localparam logic [CODE_W-1:0] CODE_CTI = 3'd6;
  localparam logic [CODE_W-1:0] CODE_THRE = 3'd1;
  localparam logic [CODE_W-1:0] CODE_MS = 3'd0;

  typedef struct packed {
    logic ierWr;
    logic idHold;
    logic rdStart;
  } irqCtlT;
endpackage

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl
  import uart_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   ierWrEn,
  input  logic   idRdEn,
  output irqCtlT ctl
);
  logic rdQ;

  always_ff @(posedge clk) begin
    if (!rstN) rdQ <= 1'b0;
    else       rdQ <= idRdEn;
  end

  always_comb begin
    ctl.ierWr   = ierWrEn;
    ctl.idHold  = idRdEn;
    ctl.rdStart = idRdEn & ~rdQ;
  end
endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  irqCtlT           ctl,
  input  logic [IER_W-1:0] ierWrData,
  input  logic             fifoEn,
  input  logic             autoCts,
  input  logic             rlsIn,
  input  logic             rdaIn,
  input  logic             ctiIn,
  input  logic             threIn,
  input  logic             thrWrite,
  input  logic             msIn,
  input  logic             ctsChg,
  input  logic             abEndIn,
  input  logic             abToIn,
  input  logic [1:0]       abClr,
  output logic [IER_W-1:0] ierQ,
  output logic [ID_W-1:0]  idQ,
  output logic             irqQ
);
  logic threQ, threFlag, abEndFlag, abToFlag;
  logic threRise, thrClr, reportThre;
  logic rlsE, rdaE, ctiE, threE, msE, abEndE, abToE;
  logic anyCoded;
  logic [CODE_W-1:0] code;
  logic [ID_W-1:0] idNext;

  always_ff @(posedge clk) begin
    if (!rstN)          ierQ <= '0;
    else if (ctl.ierWr) ierQ <= ierWrData & IER_MASK;
  end

  assign threRise   = threIn & ~threQ;
  assign reportThre = (idQ[CODE_W:0] == {CODE_THRE, 1'b0});
  assign thrClr     = thrWrite | (ctl.rdStart & reportThre);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      threQ     <= 1'b0;
      threFlag  <= 1'b0;
      abEndFlag <= 1'b0;
      abToFlag  <= 1'b0;
    end else begin
      threQ     <= threIn;
      threFlag  <= threRise | (threFlag & ~thrClr);
      abEndFlag <= abEndIn | (abEndFlag & ~abClr[0]);
      abToFlag  <= abToIn | (abToFlag & ~abClr[1]);
    end
  end

  assign rlsE   = rlsIn & ierQ[2];
  assign rdaE   = rdaIn & ierQ[0];
  assign ctiE   = ctiIn & ierQ[0];
  assign threE  = threFlag & ierQ[1];
  assign msE    = ierQ[3] & (msIn | (ctsChg & (~autoCts | ierQ[7])));
  assign abEndE = abEndFlag & ierQ[8];
  assign abToE  = abToFlag & ierQ[9];
  assign anyCoded = rlsE | rdaE | ctiE | threE | msE;

  always_comb begin
    if (rlsE)       code = CODE_RLS;
    else if (rdaE)  code = CODE_RDA;
    else if (ctiE)  code = CODE_CTI;
    else if (threE) code = CODE_THRE;
    else            code = CODE_MS;
  end

  assign idNext = {abToE, abEndE, {2{fifoEn}}, 2'b00, code, ~anyCoded};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idQ  <= ID_RESET;
      irqQ <= 1'b0;
    end else begin
      if (!ctl.idHold) idQ <= idNext;
      irqQ <= anyCoded | abEndE | abToE;
    end
  end
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ierWrEn,
  input  logic [IER_W-1:0] ierWrData,
  output logic [IER_W-1:0] ierRdData,
  input  logic             idRdEn,
  output logic [ID_W-1:0]  idRdData,
  input  logic             fifoEn,
  input  logic             autoCts,
  input  logic             rlsIn,
  input  logic             rdaIn,
  input  logic             ctiIn,
  input  logic             threIn,
  input  logic             thrWrite,
  input  logic             msIn,
  input  logic             ctsChg,
  input  logic             abEndIn,
  input  logic             abToIn,
  input  logic [1:0]       abClr,
  output logic             irqOut
);
  irqCtlT ctl;

  uart_irq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .ierWrEn(ierWrEn), .idRdEn(idRdEn), .ctl(ctl)
  );

  uart_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ierWrData(ierWrData),
    .fifoEn(fifoEn), .autoCts(autoCts), .rlsIn(rlsIn), .rdaIn(rdaIn),
    .ctiIn(ctiIn), .threIn(threIn), .thrWrite(thrWrite), .msIn(msIn),
    .ctsChg(ctsChg), .abEndIn(abEndIn), .abToIn(abToIn), .abClr(abClr),
    .ierQ(ierRdData), .idQ(idRdData), .irqQ(irqOut)
  );
endmodule

// File: rtl/uart_irq_id_chk.sv
module uart_irq_id_chk
  import uart_irq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             idRdEn,
  input logic [ID_W-1:0]  idRdData,
  input logic [IER_W-1:0] ierRdData,
  input logic             threIn,
  input logic             thrWrite,
  input logic             abEndIn,
  input logic [1:0]       abClr
);
  p_code_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    (idRdData[3:1] != 3'd4) && (idRdData[3:1] != 3'd5) && (idRdData[3:1] != 3'd7));

  p_idle_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    idRdData[0] |-> (idRdData[3:1] == 3'd0));

  p_freeze_r4: assert property (@(posedge clk) disable iff (!rstN)
    (idRdEn && $past(idRdEn)) |-> $stable(idRdData));

  p_resv_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    idRdData[5:4] == 2'b00);

  p_ier_resv_r7: assert property (@(posedge clk) disable iff (!rstN)
    ierRdData[6:4] == 3'b000);

  p_ab_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(abClr[0]) && !$past(abEndIn) && !abEndIn && !idRdEn) |=> !idRdData[8]);

  p_thre_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(thrWrite) && !$past(threIn) && !idRdEn) |=> (idRdData[3:0] != 4'h2));
endmodule

bind uart_irq_id uart_irq_id_chk u_chk (
  .clk(clk), .rstN(rstN), .idRdEn(idRdEn), .idRdData(idRdData),
  .ierRdData(ierRdData), .threIn(threIn), .thrWrite(thrWrite),
  .abEndIn(abEndIn), .abClr(abClr)
);

// File: tb/sim_uart_irq_id.sv
module sim_uart_irq_id;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ierWrEn = 1'b0;
  logic [9:0] ierWrData = '0;
  logic [9:0] ierRdData;
  logic idRdEn = 1'b0;
  logic [9:0] idRdData;
  logic fifoEn = 1'b0, autoCts = 1'b0;
  logic rlsIn = 1'b0, rdaIn = 1'b0, ctiIn = 1'b0, threIn = 1'b0, thrWrite = 1'b0;
  logic msIn = 1'b0, ctsChg = 1'b0, abEndIn = 1'b0, abToIn = 1'b0;
  logic [1:0] abClr = '0;
  logic irqOut;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  logic [9:0] mIer = '0, mId = 10'h001;
  logic mIrq = 0, mThreQ = 0, mThreFlag = 0, mAbEnd = 0, mAbTo = 0, mRdQ = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_id u0 (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] modelId();
    logic rlsE, rdaE, ctiE, threE, msE, any;
    logic [2:0] c;
    rlsE = rlsIn & mIer[2];
    rdaE = rdaIn & mIer[0];
    ctiE = ctiIn & mIer[0];
    threE = mThreFlag & mIer[1];
    msE = mIer[3] & (msIn | (ctsChg & (~autoCts | mIer[7])));
    any = rlsE | rdaE | ctiE | threE | msE;
    c = rlsE ? 3'd3 : rdaE ? 3'd2 : ctiE ? 3'd6 : threE ? 3'd1 : 3'd0;
    return {mAbTo & mIer[9], mAbEnd & mIer[8], fifoEn, fifoEn, 2'b00, c, ~any};
  endfunction

  // Starts just after a falling edge and ends on the next falling edge.
  task automatic step();
    logic [9:0] nId;
    logic nIrq, rise, rdStart, clr;
    #1;
    check(idRdData[3:0] == mId[3:0], "R2/R3 code", idRdData[3:0], mId[3:0]);
    check(idRdData[3:1] != 3'd4 && idRdData[3:1] != 3'd5 && idRdData[3:1] != 3'd7,
          "R2 legal code", idRdData[3:1], 0);
    check(idRdData[7:4] == mId[7:4], "R5 fifo copy", idRdData[7:4], mId[7:4]);
    check(idRdData[9:8] == mId[9:8], "R8 autobaud bits", idRdData[9:8], mId[9:8]);
    check(irqOut == mIrq, "R9 irq", irqOut, mIrq);
    check(ierRdData == mIer, "R7 enable reg", ierRdData, mIer);
    nId = idRdEn ? mId : modelId();
    nIrq = (modelId() & 10'h301) != 10'h001;
    rise = threIn & ~mThreQ;
    rdStart = idRdEn & ~mRdQ;
    clr = thrWrite | (rdStart & (mId[3:0] == 4'h2));
    @(posedge clk);
    mId = nId;
    mIrq = nIrq;
    mThreFlag = rise | (mThreFlag & ~clr);
    mThreQ = threIn;
    mAbEnd = abEndIn | (mAbEnd & ~abClr[0]);
    mAbTo = abToIn | (mAbTo & ~abClr[1]);
    if (ierWrEn) mIer = ierWrData & 10'h38F;
    mRdQ = idRdEn;
    @(negedge clk);
  endtask

  task automatic quiet();
    ierWrEn = 0; idRdEn = 0; thrWrite = 0; abEndIn = 0; abToIn = 0; abClr = 0;
  endtask

  task automatic setIer(input logic [9:0] v);
    ierWrEn = 1; ierWrData = v; step(); ierWrEn = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [9:0] held;
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    check(idRdData == 10'h001, "R1 reset id", idRdData, 10'h001);
    check(ierRdData == 10'h000, "R1 reset enable", ierRdData, 0);
    check(irqOut == 1'b0, "R1 reset irq", irqOut, 0);
    @(negedge clk);

    // R7: reserved enable bits never stored
    setIer(10'h3FF);
    step();
    check(ierRdData == 10'h38F, "R7 masked write", ierRdData, 10'h38F);

    // R3 priority ladder, R11 level following
    rlsIn = 1; rdaIn = 1; ctiIn = 1; msIn = 1;
    step(); step();
    check(idRdData[3:0] == 4'h6, "R3 line status first", idRdData[3:0], 6);
    rlsIn = 0; step();
    check(idRdData[3:0] == 4'h4, "R3 data available next", idRdData[3:0], 4);
    rdaIn = 0; step();
    check(idRdData[3:0] == 4'hC, "R3 timeout next", idRdData[3:0], 12);
    ctiIn = 0; step();
    check(idRdData[3:0] == 4'h0, "R3 modem last", idRdData[3:0], 0);
    msIn = 0; step();
    check(idRdData[3:0] == 4'h1, "R11 level source drops", idRdData[3:0], 1);

    // R4 freeze during a held read
    rlsIn = 1; step();
    held = idRdData;
    idRdEn = 1; rlsIn = 0; step(); rdaIn = 1; step(); step();
    #1;
    check(idRdData == held, "R4 frozen during read", idRdData, held);
    @(negedge clk);
    idRdEn = 0; step(); step();
    check(idRdData[3:0] == 4'h4, "R4 deferred event shown", idRdData[3:0], 4);
    rdaIn = 0; step(); step();

    // R6 CTS gating under auto mode
    autoCts = 1; setIer(10'h008); ctsChg = 1; step(); step();
    check(idRdData[0] == 1'b1, "R6 cts masked without bit 7", idRdData[0], 1);
    setIer(10'h088); step();
    check(idRdData[3:0] == 4'h0, "R6 cts with bit 7", idRdData[3:0], 0);
    autoCts = 0; setIer(10'h008); step();
    check(idRdData[3:0] == 4'h0, "R6 cts manual mode", idRdData[3:0], 0);
    ctsChg = 0; step();

    // R10 transmit empty set by edge, cleared by reporting read
    setIer(10'h002); threIn = 1; step(); step(); step();
    check(idRdData[3:0] == 4'h2, "R10 thre reported", idRdData[3:0], 2);
    idRdEn = 1; step(); idRdEn = 0; step(); step();
    check(idRdData[3:0] == 4'h1, "R10 cleared by read", idRdData[3:0], 1);
    threIn = 0; step(); threIn = 1; step(); step();
    thrWrite = 1; step(); thrWrite = 0; step();
    check(idRdData[3:0] == 4'h1, "R10 cleared by write", idRdData[3:0], 1);

    // R8 auto-baud sticky flags
    setIer(10'h300); abEndIn = 1; step(); abEndIn = 0; step(); step();
    check(idRdData[8] == 1'b1, "R8 end flag held", idRdData[8], 1);
    abClr = 2'b01; step(); abClr = 0; step();
    check(idRdData[8] == 1'b0, "R8 end flag cleared", idRdData[8], 0);

    // random mix, R2 R5 R7 R8 R9 R11 compared each cycle by step
    for (int i = 0; i < 4000; i++) begin
      rlsIn = ($urandom % 8) == 0; rdaIn = ($urandom % 3) == 0;
      ctiIn = ($urandom % 4) == 0; threIn = ($urandom % 2) == 0;
      msIn = ($urandom % 6) == 0; ctsChg = ($urandom % 5) == 0;
      thrWrite = ($urandom % 7) == 0; fifoEn = $urandom; autoCts = $urandom;
      abEndIn = ($urandom % 9) == 0; abToIn = ($urandom % 9) == 0;
      abClr = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      ierWrEn = ($urandom % 12) == 0; ierWrData = 10'($urandom);
      if (($urandom % 4) == 0) idRdEn = ~idRdEn;
      step();
    end
    quiet();
    step();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule